// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator

This block generates up to eight independent pulse-width modulated outputs. All channels share one register window on a simple synchronous read/write port. A single shared enable register at address 0x000 starts and stops the channels. Each channel has its own small register block, which sets three things: a power-of-two tick divider, a period length and a high-time length. Period and high time are both stored as "count minus one".

Each channel contains a three-state machine with the states `CH_OFF`, `CH_HIGH` and `CH_LOW`. It also has a prescaler counter, a period counter and shadow copies of its settings. The shadow copies are loaded only when a period starts, so a change made by software never cuts a waveform period short. Zero high time is expressed by clearing the channel's enable bit.

The named transitions are:
- **start**: `CH_OFF` to `CH_HIGH`, taken when the enable bit is seen set.
- **duty end**: `CH_HIGH` to `CH_LOW`, taken when the tick count passes the high time.
- **wrap**: `CH_HIGH` or `CH_LOW` to `CH_HIGH`, taken at the last tick of a period. It also reloads the shadows.
- **stop**: any running state to `CH_OFF`, taken when the enable bit is seen clear.

Top module: `pwm_bank`

## Requirements
- R1: Bit n of the shared enable register (byte address 0x000) enables channel n. After reset, every enable bit, every setting and every output is 0.
- R2: The register block of channel n starts at 0x010 + n*0x040. Within the block:
  - The control register is at +0x00. Bits [2:0] are the divider select and bit 15 is a stored flag. Both read back as written, and all other bits read 0.
  - The period register is at +0x2C and the high-time register is at +0x30. Each holds 13 bits, and the upper bits read 0.
- R3: A channel's period counter advances once every 2^d clocks, where d is the divider select, from 0 to 7.
- R4: One waveform period lasts (P+1) ticks, where P is the period register value.
- R5: The output is high for the first (H+1) ticks of each period and low for the rest, where H is the high-time register value.
- R6: When H >= P, the output stays high for the whole period.
- R7: If the enable bit of a channel was 0 at a clock edge, the output is low after the next edge. While disabled, the channel holds its counters at zero.
- R8: On the clock edge after the enable bit becomes 1, the channel starts a fresh period with its output high. It uses the settings present at that edge.
- R9: Writes to the divider, period or high-time registers of a running channel take effect at the start of the next period.
- R10: Registers of channels at or above NUM_CH, unmapped offsets, and enable bits at or above NUM_CH read as 0. Writes to them have no effect.
- R11: Read data is registered. It shows the register addressed in the previous cycle, and a read in the same cycle as a write returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| pwm_o | output | NUM_CH | One waveform output per channel |

## Verification
On every cycle, the checker confirms four things:
- a disabled channel is low after one edge;
- a newly enabled channel starts high;
- the enable vector only changes on a write;
- enable-register reads never show bits above the channel count.

Only the bench can show the waveform timing itself: the length of the high and low phases for each divider, period and high-time combination, saturation when the high time reaches the period, and settings deferred to the next period boundary. It also covers register readback, and writes to absent channels that are ignored.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
    localparam int CNT_W     = 13;
    localparam int DIV_W     = 3;
    localparam int KEEP_BIT  = 15;
    localparam int CH_BASE   = 'h010;
    localparam int CH_STRIDE = 'h040;
    localparam int OFS_CTRL  = 'h000;
    localparam int OFS_PER   = 'h02C;
    localparam int OFS_DTY   = 'h030;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_HIGH = 2'd1,
        CH_LOW  = 2'd2
    } ch_state_e;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           wr_en,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output logic [NUM_CH-1:0]              chan_en,
    output logic [NUM_CH-1:0][DIV_W-1:0]   cfg_div,
    output logic [NUM_CH-1:0][CNT_W-1:0]   cfg_per,
    output logic [NUM_CH-1:0][CNT_W-1:0]   cfg_dty
);
    localparam logic [ADDR_W-1:0] GLB_ADDR = '0;

    function automatic logic [ADDR_W-1:0] blk_addr(input int ch, input int ofs);
        return ADDR_W'(CH_BASE + ch * CH_STRIDE + ofs);
    endfunction

    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] keep_v;
    logic [DATA_W-1:0] rd_d;
    logic [DATA_W-1:0] rd_q;

    // shared enable register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && addr == GLB_ADDR) begin
            en_q <= wdata[NUM_CH-1:0];
        end
    end

    // per-channel setting registers
    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_chreg
            logic             keep_q;
            logic [DIV_W-1:0] div_q;
            logic [CNT_W-1:0] per_q;
            logic [CNT_W-1:0] dty_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    keep_q <= 1'b0;
                    div_q  <= '0;
                    per_q  <= '0;
                    dty_q  <= '0;
                end else if (wr_en) begin
                    if (addr == blk_addr(g, OFS_CTRL)) begin
                        keep_q <= wdata[KEEP_BIT];
                        div_q  <= wdata[DIV_W-1:0];
                    end
                    if (addr == blk_addr(g, OFS_PER)) begin
                        per_q <= wdata[CNT_W-1:0];
                    end
                    if (addr == blk_addr(g, OFS_DTY)) begin
                        dty_q <= wdata[CNT_W-1:0];
                    end
                end
            end

            assign keep_v[g]  = keep_q;
            assign cfg_div[g] = div_q;
            assign cfg_per[g] = per_q;
            assign cfg_dty[g] = dty_q;
        end
    endgenerate

    // read multiplexer
    always_comb begin
        rd_d = '0;
        if (addr == GLB_ADDR) begin
            rd_d[NUM_CH-1:0] = en_q;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == blk_addr(c, OFS_CTRL)) begin
                rd_d[KEEP_BIT]    = keep_v[c];
                rd_d[DIV_W-1:0]   = cfg_div[c];
            end
            if (addr == blk_addr(c, OFS_PER)) begin
                rd_d[CNT_W-1:0] = cfg_per[c];
            end
            if (addr == blk_addr(c, OFS_DTY)) begin
                rd_d[CNT_W-1:0] = cfg_dty[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata   = rd_q;
    assign chan_en = en_q;
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [CNT_W-1:0] cfg_per,
    input  logic [CNT_W-1:0] cfg_dty,
    output logic             pwm
);
    localparam int PRE_W = (1 << DIV_W) - 1;
    localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

    ch_state_e        state_q, state_d;
    logic [PRE_W-1:0] pre_q, pre_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] div_sh_q, div_sh_d;
    logic [CNT_W-1:0] per_sh_q, per_sh_d;
    logic [CNT_W-1:0] dty_sh_q, dty_sh_d;
    logic [PRE_W-1:0] pre_lim;
    logic [CNT_W-1:0] cnt_inc;
    logic             tick;
    logic             pwm_q;

    assign pre_lim = (PRE_ONE << div_sh_q) - PRE_ONE;
    assign tick    = (pre_q == pre_lim);
    assign cnt_inc = cnt_q + CNT_W'(1);

    // next state and datapath
    always_comb begin
        state_d  = state_q;
        pre_d    = pre_q;
        cnt_d    = cnt_q;
        div_sh_d = div_sh_q;
        per_sh_d = per_sh_q;
        dty_sh_d = dty_sh_q;
        unique case (state_q)
            CH_OFF: begin
                pre_d    = '0;
                cnt_d    = '0;
                div_sh_d = cfg_div;
                per_sh_d = cfg_per;
                dty_sh_d = cfg_dty;
                if (en) begin
                    state_d = CH_HIGH;   // start
                end
            end
            CH_HIGH, CH_LOW: begin
                if (!en) begin
                    state_d = CH_OFF;    // stop
                    pre_d   = '0;
                    cnt_d   = '0;
                end else if (tick) begin
                    pre_d = '0;
                    if (cnt_q == per_sh_q) begin
                        state_d  = CH_HIGH;   // wrap
                        cnt_d    = '0;
                        div_sh_d = cfg_div;
                        per_sh_d = cfg_per;
                        dty_sh_d = cfg_dty;
                    end else begin
                        cnt_d   = cnt_inc;
                        state_d = (cnt_inc <= dty_sh_q) ? CH_HIGH : CH_LOW;  // duty end
                    end
                end else begin
                    pre_d = pre_q + PRE_ONE;
                end
            end
            default: begin
                state_d = CH_OFF;
                pre_d   = '0;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= CH_OFF;
            pre_q    <= '0;
            cnt_q    <= '0;
            div_sh_q <= '0;
            per_sh_q <= '0;
            dty_sh_q <= '0;
        end else begin
            state_q  <= state_d;
            pre_q    <= pre_d;
            cnt_q    <= cnt_d;
            div_sh_q <= div_sh_d;
            per_sh_q <= per_sh_d;
            dty_sh_q <= dty_sh_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= (state_d == CH_HIGH);
        end
    end

    assign pwm = pwm_q;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] pwm_o
);
    logic [NUM_CH-1:0]            chan_en;
    logic [NUM_CH-1:0][DIV_W-1:0] cfg_div;
    logic [NUM_CH-1:0][CNT_W-1:0] cfg_per;
    logic [NUM_CH-1:0][CNT_W-1:0] cfg_dty;

    pwm_bank_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .chan_en (chan_en),
        .cfg_div (cfg_div),
        .cfg_per (cfg_per),
        .cfg_dty (cfg_dty)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_chan
            pwm_bank_chan chan_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (chan_en[g]),
                .cfg_div (cfg_div[g]),
                .cfg_per (cfg_per[g]),
                .cfg_dty (cfg_dty[g]),
                .pwm     (pwm_o[g])
            );
        end
    endgenerate
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] rdata,
    input logic [NUM_CH-1:0] chan_en,
    input logic [NUM_CH-1:0] pwm_o
);
    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            // R7
            off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !chan_en[g] |=> !pwm_o[g]);
            // R8
            start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(chan_en[g]) |=> pwm_o[g]);
        end
    endgenerate

    // R1
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(chan_en));

    // R10
    glb_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(addr) == '0) |-> (rdata[DATA_W-1:NUM_CH] == '0));
endmodule

bind pwm_bank pwm_bank_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .rdata   (rdata),
    .chan_en (chan_en),
    .pwm_o   (pwm_o)
);

// File: tb/pwm_bank_tb_top.sv
module pwm_bank_tb_top;
    localparam int NUM_CH = 4;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic [NUM_CH-1:0] pwm_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int dv [NUM_CH];
    int pr [NUM_CH];
    int dt [NUM_CH];

    always #10 clk = ~clk;

    pwm_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
    );

    function automatic int ch_addr(input int ch, input int ofs);
        return 'h010 + ch * 'h040 + ofs;
    endfunction

    function automatic bit exp_lvl(input int t, input int d, input int p, input int h);
        int pos;
        pos = (t >> d) % (p + 1);
        return (h >= p) || (pos <= h);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        addr  = ADDR_W'(a);
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        addr  = ADDR_W'(a);
        wr_en = 1'b0;
        @(negedge clk);
        d = rdata;
    endtask

    task automatic cfg_ch(input int ch, input int d, input int p, input int h);
        dv[ch] = d; pr[ch] = p; dt[ch] = h;
        wr(ch_addr(ch, 'h000), DATA_W'(32'h8000 | d));
        wr(ch_addr(ch, 'h02C), DATA_W'(p));
        wr(ch_addr(ch, 'h030), DATA_W'(h));
    endtask

    // call right after the enabling write returns
    task automatic run_win(input int mask, input int ncyc, input string req);
        int errs [NUM_CH];
        int fa [NUM_CH];
        int fe [NUM_CH];
        bit e;
        for (int c = 0; c < NUM_CH; c++) begin errs[c] = 0; fa[c] = 0; fe[c] = 0; end
        @(negedge clk);
        for (int t = 0; t < ncyc; t++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                e = mask[c] ? exp_lvl(t, dv[c], pr[c], dt[c]) : 1'b0;
                if (pwm_o[c] !== e && errs[c] == 0) begin
                    fa[c] = {31'd0, pwm_o[c]};
                    fe[c] = {31'd0, e};
                    $display("  mismatch ch%0d at t=%0d", c, t);
                end
                if (pwm_o[c] !== e) errs[c]++;
            end
            @(negedge clk);
        end
        for (int c = 0; c < NUM_CH; c++) chk(errs[c] == 0, req, fa[c], fe[c]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] r;
        bit e;
        int d;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R11 reset state
        @(negedge clk);
        chk(pwm_o == '0, "R1 reset outputs", int'(pwm_o), 0);
        rd('h000, r);
        chk(r == '0, "R11 reset enable reg", int'(r), 0);
        rd(ch_addr(0, 'h02C), r);
        chk(r == '0, "R11 reset period reg", int'(r), 0);

        // R2 readback masking
        wr(ch_addr(NUM_CH-1, 'h000), '1);
        rd(ch_addr(NUM_CH-1, 'h000), r);
        chk(r == 32'h8007, "R2 ctrl readback", int'(r), 'h8007);
        wr(ch_addr(1, 'h02C), '1);
        rd(ch_addr(1, 'h02C), r);
        chk(r == 32'h1FFF, "R2 period readback", int'(r), 'h1FFF);
        wr(ch_addr(2, 'h030), 32'h0000_0ABC);
        rd(ch_addr(2, 'h030), r);
        chk(r == 32'h0ABC, "R2 duty readback", int'(r), 'hABC);

        // R10 enable reg upper bits, absent channel, unmapped offset
        wr('h000, '1);
        rd('h000, r);
        chk(r == DATA_W'((1 << NUM_CH) - 1), "R10 enable upper bits", int'(r), (1 << NUM_CH) - 1);
        wr('h000, '0);
        wr(ch_addr(NUM_CH, 'h02C), '1);
        rd(ch_addr(NUM_CH, 'h02C), r);
        chk(r == '0, "R10 absent channel", int'(r), 0);
        wr('h004, '1);
        rd('h004, r);
        chk(r == '0, "R10 unmapped offset", int'(r), 0);
        chk(pwm_o == '0, "R10 no output effect", int'(pwm_o), 0);

        // R11 read in same cycle as write returns old value
        wr(ch_addr(0, 'h030), 32'd7);
        @(negedge clk);
        addr = ADDR_W'(ch_addr(0, 'h030)); wdata = 32'd9; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(rdata == 32'd7, "R11 read during write", int'(rdata), 7);

        // R3 largest divider
        for (int c = 0; c < NUM_CH; c++) cfg_ch(c, 0, 0, 0);
        cfg_ch(0, 7, 1, 0);
        wr('h000, 32'h1);
        run_win(1, 600, "R3 divider 7");

        // R7 disable, then R8 fresh start; R6 saturation
        wr('h000, 32'h0);
        @(negedge clk);
        chk(pwm_o[0] == 1'b0, "R7 low after disable", int'(pwm_o[0]), 0);
        cfg_ch(0, 0, 20, 20);
        cfg_ch(1, 1, 5, 30);
        wr('h000, 32'h3);
        run_win(3, 100, "R6 saturation");
        wr('h000, 32'h0);
        @(negedge clk);
        chk(pwm_o == '0, "R7 all low", int'(pwm_o), 0);
        cfg_ch(0, 1, 3, 0);
        wr('h000, 32'h1);
        run_win(1, 60, "R8 fresh period");

        // R9 deferred update
        wr('h000, 32'h0);
        cfg_ch(1, 0, 9, 4);
        wr('h000, 32'h2);
        d = 0;
        @(negedge clk);
        for (int t = 0; t < 40; t++) begin
            e = (t < 10) ? exp_lvl(t, 0, 9, 4) : exp_lvl(t - 10, 0, 5, 1);
            if (pwm_o[1] !== e) begin
                if (d == 0) $display("  mismatch R9 at t=%0d", t);
                d++;
            end
            if (t == 2) begin
                addr = ADDR_W'(ch_addr(1, 'h02C)); wdata = 32'd5; wr_en = 1'b1;
            end else if (t == 3) begin
                addr = ADDR_W'(ch_addr(1, 'h030)); wdata = 32'd1; wr_en = 1'b1;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        chk(d == 0, "R9 change at boundary", d, 0);

        // R4 R5 R6 random configurations
        for (int it = 0; it < 12; it++) begin
            int mask;
            wr('h000, 32'h0);
            @(negedge clk);
            chk(pwm_o == '0, "R7 stop before reconfig", int'(pwm_o), 0);
            for (int c = 0; c < NUM_CH; c++)
                cfg_ch(c, int'($urandom % 4), int'($urandom % 41), int'($urandom % 46));
            mask = int'($urandom % (1 << NUM_CH)) | 1;
            wr('h000, DATA_W'(mask));
            run_win(mask, 700, "R4 R5 random pattern");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule